// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block tracks the reservation that one core holds for a load-reserve / store-conditional pair. It observes the core's stream of memory accesses. Each access is presented for one cycle with a valid strobe, an access kind, an address and a transaction size. The block keeps at most one reservation: an address together with the size of the load-exclusive that created it.

Every store-exclusive gets a pass or fail verdict. The verdict is registered and appears, with a qualifying flag, in the cycle after the strobe. A pass only means this core's reservation still matched. A global monitor outside this block combines the verdict with what the other cores did and makes the final decision. The block never reads or writes memory data.

The rules are deliberately conservative. Any plain load or plain store seen while a reservation is held drops it, whatever its address. A store-exclusive needs both the address and the size to match, and it always ends the reservation.

Top module: `excl_mon`

## Requirements
- R1: After reset the monitor holds no reservation. The recorded address is zero, the recorded size is None, and `sx_done` and `sx_pass` are low.
- R2: A load-exclusive (kind code 2'b10) always leaves a reservation held and records its address and size. This replaces any reservation held before it.
- R3: A plain load (kind code 2'b00) seen while a reservation is held drops the reservation, whether or not its address matches.
- R4: A plain store (kind code 2'b01) seen while a reservation is held drops the reservation, whether or not its address matches.
- R5: A store-exclusive (kind code 2'b11) seen while a reservation is held passes only if both its address and its size equal the recorded ones. The reservation is dropped whether it passes or fails.
- R6: A store-exclusive seen while no reservation is held fails and leaves the monitor unchanged.
- R7: `sx_done` is high for exactly the one cycle after each store-exclusive strobe and is low otherwise. `sx_pass` is never high while `sx_done` is low.
- R8: A plain load or plain store seen while no reservation is held has no effect. A cycle without the valid strobe leaves the reservation as it was.
- R9: Sizes are 2-bit codes: 2'b01 byte, 2'b10 halfword, 2'b11 word. Code 2'b00 (None) marks an empty reservation and is not a legal access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 load, 01 store, 10 load-exclusive, 11 store-exclusive |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | 2 | 01 byte, 10 halfword, 11 word |
| sx_done | output | 1 | A store-exclusive verdict is valid this cycle |
| sx_pass | output | 1 | The local verdict for that store-exclusive is pass |

## Verification
The hardest cases to observe are the ones that quietly drop a reservation or quietly leave it alone. A plain access with an unrelated address, a failed store-exclusive, and idle cycles all show nothing at the ports until a later store-exclusive probes the state. The directed sequences therefore always follow the disturbing access with a store-exclusive that would have passed had the reservation survived. The random phase draws addresses from a pool of four neighbouring values and uses all three sizes, so that matches, near misses, and same-address different-size cases occur often.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_LDX   = 2'b10,
    ACC_STX   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_WORD = 2'b11
  } acc_size_e;

endpackage

// File: rtl/excl_mon_decode.sv
module excl_mon_decode
  import excl_mon_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] kind,
  output logic       is_ld,
  output logic       is_st,
  output logic       is_ldx,
  output logic       is_stx
);
  always_comb begin
    is_ld  = 1'b0;
    is_st  = 1'b0;
    is_ldx = 1'b0;
    is_stx = 1'b0;
    if (valid) begin
      unique case (acc_kind_e'(kind))
        ACC_LOAD:  is_ld  = 1'b1;
        ACC_STORE: is_st  = 1'b1;
        ACC_LDX:   is_ldx = 1'b1;
        ACC_STX:   is_stx = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/excl_mon_rsv.sv
module excl_mon_rsv
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_ld,
  input  logic              is_st,
  input  logic              is_ldx,
  input  logic              is_stx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              held,
  output logic [ADDR_W-1:0] tag_addr,
  output logic [1:0]        tag_size,
  output logic              hit
);
  logic drop;

  // Any non-reserving access ends a held reservation.
  assign drop = held & (is_ld | is_st | is_stx);
  assign hit  = held & (addr == tag_addr) & (size == tag_size);

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      tag_addr <= '0;
      tag_size <= SZ_NONE;
    end else if (is_ldx) begin
      held     <= 1'b1;
      tag_addr <= addr;
      tag_size <= size;
    end else if (drop) begin
      held     <= 1'b0;
      tag_addr <= '0;
      tag_size <= SZ_NONE;
    end
  end
endmodule

// File: rtl/excl_mon_verdict.sv
module excl_mon_verdict (
  input  logic clk,
  input  logic rst,
  input  logic is_stx,
  input  logic hit,
  output logic done,
  output logic pass
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else begin
      done <= is_stx;
      pass <= is_stx & hit;
    end
  end
endmodule

// File: rtl/excl_mon.sv
module excl_mon #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic              sx_done,
  output logic              sx_pass
);
  logic              is_ld, is_st, is_ldx, is_stx;
  logic              rsv_held, rsv_hit;
  logic [ADDR_W-1:0] rsv_addr;
  logic [1:0]        rsv_size;

  excl_mon_decode u_dec (
    .valid (acc_valid),
    .kind  (acc_kind),
    .is_ld (is_ld),
    .is_st (is_st),
    .is_ldx(is_ldx),
    .is_stx(is_stx)
  );

  excl_mon_rsv #(.ADDR_W(ADDR_W)) u_rsv (
    .clk     (clk),
    .rst     (rst),
    .is_ld   (is_ld),
    .is_st   (is_st),
    .is_ldx  (is_ldx),
    .is_stx  (is_stx),
    .addr    (acc_addr),
    .size    (acc_size),
    .held    (rsv_held),
    .tag_addr(rsv_addr),
    .tag_size(rsv_size),
    .hit     (rsv_hit)
  );

  excl_mon_verdict u_vrd (
    .clk   (clk),
    .rst   (rst),
    .is_stx(is_stx),
    .hit   (rsv_hit),
    .done  (sx_done),
    .pass  (sx_pass)
  );
endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [1:0]        acc_kind,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic              sx_done,
  input logic              sx_pass,
  input logic              held,
  input logic [ADDR_W-1:0] tag_addr,
  input logic [1:0]        tag_size
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1: an empty reservation carries zero address and None size
  a_r1_empty_tag: assert property (@(posedge clk) disable iff (rst)
    !held |-> (tag_addr == '0 && tag_size == 2'b00));

  // R2: a load-exclusive leaves its address and size recorded
  a_r2_ldx_records: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (acc_valid && acc_kind == 2'b10) |=>
      (held && tag_addr == $past(acc_addr) && tag_size == $past(acc_size)));

  // R3 R4 R5: any other access leaves nothing reserved
  a_r5_other_clears: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (acc_valid && acc_kind != 2'b10) |=> !held);

  // R5: a pass needs the matching reservation in the strobe cycle
  a_r5_pass_needs_match: assert property (@(posedge clk) disable iff (rst || !past_ok)
    sx_pass |-> ($past(held) && $past(acc_addr) == $past(tag_addr)
                 && $past(acc_size) == $past(tag_size)));

  // R7: verdict flag only after a store-exclusive strobe
  a_r7_done_after_stx: assert property (@(posedge clk) disable iff (rst || !past_ok)
    sx_done |-> $past(acc_valid && acc_kind == 2'b11));

  // R7: a store-exclusive always gets a verdict
  a_r7_stx_gets_done: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b11) |=> sx_done);

  // R7: pass is qualified by done
  a_r7_pass_qualified: assert property (@(posedge clk) disable iff (rst)
    sx_pass |-> sx_done);

  // R8: idle cycles keep the reservation
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !acc_valid |=> ($stable(held) && $stable(tag_addr) && $stable(tag_size)));
endmodule

bind excl_mon excl_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_valid(acc_valid),
  .acc_kind (acc_kind),
  .acc_addr (acc_addr),
  .acc_size (acc_size),
  .sx_done  (sx_done),
  .sx_pass  (sx_pass),
  .held     (rsv_held),
  .tag_addr (rsv_addr),
  .tag_size (rsv_size)
);

// File: tb/tb_excl_mon.sv
module tb_excl_mon;
  localparam int ADDR_W = 32;
  localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_LDX = 2'b10, K_STX = 2'b11;
  localparam logic [1:0] S_B = 2'b01, S_H = 2'b10, S_W = 2'b11;

  logic              clk = 1'b0;
  logic              rst;
  logic              acc_valid;
  logic [1:0]        acc_kind;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        acc_size;
  logic              sx_done, sx_pass;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // bench reservation model
  bit                m_held = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [1:0]        m_size = 2'b00;

  always #5 clk = ~clk;

  excl_mon #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_size(acc_size), .sx_done(sx_done), .sx_pass(sx_pass)
  );

  function automatic bit exp_pass(logic [1:0] k, logic [ADDR_W-1:0] a, logic [1:0] s);
    return (k == K_STX) && m_held && (a == m_addr) && (s == m_size);
  endfunction

  task automatic model_step(logic [1:0] k, logic [ADDR_W-1:0] a, logic [1:0] s);
    if (k == K_LDX) begin
      m_held = 1'b1; m_addr = a; m_size = s;
    end else if (m_held) begin
      m_held = 1'b0; m_addr = '0; m_size = 2'b00;
    end
  endtask

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual done/pass=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(logic [1:0] k, logic [ADDR_W-1:0] a, logic [1:0] s, string req);
    bit ep;
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_size = s;
    ep = exp_pass(k, a, s);
    model_step(k, a, s);
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, {sx_done, sx_pass}, {k == K_STX, ep});
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      acc_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; acc_valid = 1'b0; acc_kind = K_LD; acc_addr = '0; acc_size = S_W;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {sx_done, sx_pass}, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {sx_done, sx_pass}, 2'b00);

    // R6: store-exclusive with no reservation (also probes R1 empty state)
    access(K_STX, 32'h0, 2'b00, "R6 stx open size none");
    access(K_STX, 32'h40, S_W, "R6 stx open");
    // R2 / R5: matching pair
    access(K_LDX, 32'h40, S_W, "R2 ldx");
    access(K_STX, 32'h40, S_W, "R5 match passes");
    access(K_STX, 32'h40, S_W, "R5 reservation ended after pass");
    // R5: size mismatch
    access(K_LDX, 32'h80, S_H, "R2 ldx half");
    access(K_STX, 32'h80, S_W, "R5 size mismatch fails");
    access(K_STX, 32'h80, S_H, "R5 ended after fail");
    // R5: address mismatch
    access(K_LDX, 32'h80, S_B, "R2 ldx byte");
    access(K_STX, 32'h81, S_B, "R5 addr mismatch fails");
    access(K_STX, 32'h80, S_B, "R5 ended after addr fail");
    // R3: unrelated load drops
    access(K_LDX, 32'h100, S_W, "R2 ldx");
    access(K_LD,  32'h900, S_W, "R3 plain load");
    access(K_STX, 32'h100, S_W, "R3 load dropped reservation");
    // R4: unrelated store drops
    access(K_LDX, 32'h100, S_W, "R2 ldx");
    access(K_ST,  32'h904, S_B, "R4 plain store");
    access(K_STX, 32'h100, S_W, "R4 store dropped reservation");
    // R2: replacement
    access(K_LDX, 32'h200, S_W, "R2 ldx first");
    access(K_LDX, 32'h300, S_H, "R2 ldx replaces");
    access(K_STX, 32'h200, S_W, "R2 old reservation gone");
    access(K_LDX, 32'h200, S_W, "R2 ldx first again");
    access(K_LDX, 32'h300, S_H, "R2 ldx replaces again");
    access(K_STX, 32'h300, S_H, "R2 new reservation passes");
    // R8: plain accesses while open, idle while held
    access(K_LD,  32'h400, S_W, "R8 load while open");
    access(K_ST,  32'h400, S_W, "R8 store while open");
    access(K_LDX, 32'h400, S_W, "R2 ldx");
    idle(5);
    check("R7 no verdict while idle", {sx_done, sx_pass}, 2'b00);
    access(K_STX, 32'h400, S_W, "R8 idle keeps reservation");
    // R6: open stx does not create state
    access(K_STX, 32'h500, S_B, "R6 stx open");
    access(K_STX, 32'h500, S_B, "R6 still open");
    // R9: each size code distinguished
    access(K_LDX, 32'h600, S_B, "R9 byte");
    access(K_STX, 32'h600, S_H, "R9 byte vs half");
    access(K_LDX, 32'h600, S_H, "R9 half");
    access(K_STX, 32'h600, S_H, "R9 half matches");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [1:0] k;
      r = $urandom_range(0, 9);
      k = (r < 3) ? K_LDX : (r < 6) ? K_STX : (r < 8) ? K_LD : K_ST;
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
      access(k, 32'h1000 + ADDR_W'($urandom_range(0, 3)),
             2'($urandom_range(1, 3)), "R5 random mix");
    end

    idle(2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule